// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block keeps the stack pointer of an 8051-style core whose stack may grow past 256 bytes. The pointer is 11 bits wide. Software sees it as two special-function registers: a low byte and a high register, of which only bits 2:0 are kept. A configuration bit chooses where the stack lives. When the bit is clear, the pointer acts as an 8-bit value inside the 256-byte on-chip data RAM. When it is set, the pointer addresses a 2 KB on-chip extended RAM, and the low 256 bytes of that RAM are shared by data and stack.

The core raises a push strobe for push and call, and a pop strobe for pop and return. In the same cycle the block presents the RAM address for that access and a select line naming the RAM that serves it. The pointer moves at the end of that cycle. Push increments the pointer before the write. Pop reads at the current pointer and then decrements it. A direct SFR write to either register in the same cycle overrides the step.

Top module: `xstack_ptr_unit`

## Requirements
- R1: After reset the low register reads 07h and the high register reads 00h, so the first push goes to address 008h.
- R2: The low register sits at SFR address 81h and the high register at B7h, where bits 2:0 hold pointer bits 10:8. Reads of any other SFR address return 00h, and writes to other addresses change neither register.
- R3: The high register always reads 0 in bits 7:3, and writes to those bits are ignored.
- R4: In a cycle with push high and pop low, stk_addr_o equals the incremented pointer, and the pointer holds that value after the clock edge.
- R5: In a cycle with pop high and push low, stk_addr_o equals the current pointer, and after the clock edge the pointer is one lower.
- R6: With cfg_ext_en_i = 0 only the low byte steps. It wraps between FFh and 00h, the high register is left unchanged, and stk_addr_o[10:8] is 0.
- R7: With cfg_ext_en_i = 1 the pointer steps modulo 2048. It carries and borrows between the low and high registers, and it wraps between 7FFh and 000h.
- R8: An SFR write to 81h or B7h in the same cycle as push or pop stores the written value, and the pointer does not step in that cycle.
- R9: stk_xram_o is 1 when the stack access targets the extended RAM (cfg_ext_en_i = 1) and 0 when it targets the 256-byte internal RAM.
- R10: When push and pop are high together, or neither is high, the pointer does not change and stk_addr_o shows the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ext_en_i | input | 1 | Extended-stack enable (configuration bit 7) |
| sfr_addr_i | input | 8 | SFR direct address for reads and writes |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data (combinational) |
| push_i | input | 1 | Push or call strobe |
| pop_i | input | 1 | Pop or return strobe |
| stk_addr_o | output | 11 | Stack RAM address for this cycle's access |
| stk_xram_o | output | 1 | 1 selects the extended RAM, 0 the internal RAM |

## Verification
A wrong pointer shows on stk_addr_o in the very next push or pop cycle. It also shows at once on an SFR read of 81h or B7h, because the read path is combinational. Faults at the carry or borrow boundary, or high bits leaking in 8-bit mode, appear only when the pointer crosses FFh or 7FFh. The bench therefore steps the pointer across those edges in both modes and reads both registers after each step. A lost write priority shows one cycle later as a pointer that is one step away from the written value.

// File: rtl/xsp_pkg.sv
package xsp_pkg;
  typedef enum logic [1:0] {
    XSP_HOLD = 2'd0,
    XSP_INC  = 2'd1,
    XSP_DEC  = 2'd2
  } xsp_op_e;
endpackage

// File: rtl/xsp_step.sv
module xsp_step
  import xsp_pkg::*;
#(
  parameter int unsigned PTR_W = 11,
  parameter int unsigned LO_W  = 8
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             ext_en_i,
  input  logic             push_i,
  input  logic             pop_i,
  output xsp_op_e          op_o,
  output logic [PTR_W-1:0] nxt_o,
  output logic [PTR_W-1:0] acc_addr_o
);
  localparam int unsigned HI_W = PTR_W - LO_W;

  logic [PTR_W-1:0] full_inc, full_dec, byte_inc, byte_dec, inc_v, dec_v;
  logic [LO_W-1:0]  lo_inc, lo_dec;

  always_comb begin
    op_o = XSP_HOLD;
    if (push_i && !pop_i)      op_o = XSP_INC;
    else if (pop_i && !push_i) op_o = XSP_DEC;
  end

  // mode 0 wraps inside the low byte, high bits kept
  assign full_inc = PTR_W'(ptr_i + PTR_W'(1));
  assign full_dec = PTR_W'(ptr_i - PTR_W'(1));
  assign lo_inc   = LO_W'(ptr_i[LO_W-1:0] + LO_W'(1));
  assign lo_dec   = LO_W'(ptr_i[LO_W-1:0] - LO_W'(1));
  assign byte_inc = {ptr_i[PTR_W-1:LO_W], lo_inc};
  assign byte_dec = {ptr_i[PTR_W-1:LO_W], lo_dec};
  assign inc_v    = ext_en_i ? full_inc : byte_inc;
  assign dec_v    = ext_en_i ? full_dec : byte_dec;

  always_comb begin
    unique case (op_o)
      XSP_INC: nxt_o = inc_v;
      XSP_DEC: nxt_o = dec_v;
      default: nxt_o = ptr_i;
    endcase
  end

  // internal RAM sees only the low byte
  logic [PTR_W-1:0] raw_addr;
  assign raw_addr   = (op_o == XSP_INC) ? inc_v : ptr_i;
  assign acc_addr_o = ext_en_i ? raw_addr : {{HI_W{1'b0}}, raw_addr[LO_W-1:0]};
endmodule

// File: rtl/xsp_regs.sv
module xsp_regs #(
  parameter int unsigned LO_W   = 8,
  parameter int unsigned HI_W   = 3,
  parameter logic [LO_W-1:0] RST_LO = 8'h07
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_lo_i,
  input  logic                 wr_hi_i,
  input  logic [LO_W-1:0]      wdata_i,
  input  logic                 step_i,
  input  logic [LO_W+HI_W-1:0] nxt_i,
  output logic [LO_W-1:0]      lo_o,
  output logic [HI_W-1:0]      hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= RST_LO;
      hi_o <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      // direct write wins over any step
      if (wr_lo_i) lo_o <= wdata_i;
      if (wr_hi_i) hi_o <= wdata_i[HI_W-1:0];
    end else if (step_i) begin
      {hi_o, lo_o} <= nxt_i;
    end
  end

  // R8: write cycles never carry a step into the other register
  a_r8_hi_untouched_on_lo_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> hi_o == $past(hi_o));
  a_r8_lo_untouched_on_hi_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> lo_o == $past(lo_o));
endmodule

// File: rtl/xsp_readback.sv
module xsp_readback #(
  parameter int unsigned SFR_AW = 8,
  parameter int unsigned LO_W   = 8,
  parameter int unsigned HI_W   = 3,
  parameter logic [SFR_AW-1:0] LO_ADDR = 8'h81,
  parameter logic [SFR_AW-1:0] HI_ADDR = 8'hB7
) (
  input  logic [SFR_AW-1:0] addr_i,
  input  logic [LO_W-1:0]   lo_i,
  input  logic [HI_W-1:0]   hi_i,
  output logic [LO_W-1:0]   rdata_o
);
  localparam int unsigned PAD_W = LO_W - HI_W;

  logic [LO_W-1:0] hi_ext;
  generate
    if (PAD_W > 0) begin : g_pad
      assign hi_ext = {{PAD_W{1'b0}}, hi_i};
    end else begin : g_nopad
      assign hi_ext = hi_i[LO_W-1:0];
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (addr_i == LO_ADDR)      rdata_o = lo_i;
    else if (addr_i == HI_ADDR) rdata_o = hi_ext;
  end

  // R3: unused upper bits of the high register read as zero
  always_comb begin
    if (addr_i == HI_ADDR && PAD_W > 0)
      a_r3_hi_pad_zero: assert ((rdata_o >> HI_W) == '0);
  end
endmodule

// File: rtl/xstack_ptr_unit.sv
module xstack_ptr_unit
  import xsp_pkg::*;
#(
  parameter int unsigned SFR_AW = 8,
  parameter int unsigned PTR_W  = 11,
  parameter int unsigned LO_W   = 8,
  parameter logic [SFR_AW-1:0] LO_ADDR = 8'h81,
  parameter logic [SFR_AW-1:0] HI_ADDR = 8'hB7,
  parameter logic [LO_W-1:0]   RST_LO  = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_ext_en_i,
  input  logic [SFR_AW-1:0] sfr_addr_i,
  input  logic              sfr_we_i,
  input  logic [LO_W-1:0]   sfr_wdata_i,
  output logic [LO_W-1:0]   sfr_rdata_o,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [PTR_W-1:0]  stk_addr_o,
  output logic              stk_xram_o
);
  localparam int unsigned HI_W = PTR_W - LO_W;

  logic [LO_W-1:0]  lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [PTR_W-1:0] ptr, nxt;
  logic             wr_lo, wr_hi;
  xsp_op_e          op;

  assign ptr   = {hi_q, lo_q};
  assign wr_lo = sfr_we_i && (sfr_addr_i == LO_ADDR);
  assign wr_hi = sfr_we_i && (sfr_addr_i == HI_ADDR);

  xsp_step #(.PTR_W(PTR_W), .LO_W(LO_W)) i_step (
    .ptr_i      (ptr),
    .ext_en_i   (cfg_ext_en_i),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .op_o       (op),
    .nxt_o      (nxt),
    .acc_addr_o (stk_addr_o)
  );

  xsp_regs #(.LO_W(LO_W), .HI_W(HI_W), .RST_LO(RST_LO)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (sfr_wdata_i),
    .step_i  (op != XSP_HOLD),
    .nxt_i   (nxt),
    .lo_o    (lo_q),
    .hi_o    (hi_q)
  );

  xsp_readback #(.SFR_AW(SFR_AW), .LO_W(LO_W), .HI_W(HI_W),
                 .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) i_rdback (
    .addr_i  (sfr_addr_i),
    .lo_i    (lo_q),
    .hi_i    (hi_q),
    .rdata_o (sfr_rdata_o)
  );

  assign stk_xram_o = cfg_ext_en_i;

  logic no_wr;
  assign no_wr = !wr_lo && !wr_hi;

  // R4: push address becomes the stored pointer
  a_r4_push_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && no_wr && cfg_ext_en_i) |=> ptr == $past(stk_addr_o));
  // R7: extended mode steps modulo 2^PTR_W
  a_r7_inc_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && no_wr && cfg_ext_en_i) |=> ptr == PTR_W'($past(ptr) + PTR_W'(1)));
  a_r7_dec_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && no_wr && cfg_ext_en_i) |=> ptr == PTR_W'($past(ptr) - PTR_W'(1)));
  // R6: 8-bit mode leaves the high register and drives a byte address
  a_r6_hi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_ext_en_i && no_wr) |=> hi_q == $past(hi_q));
  a_r6_byte_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ext_en_i |-> (stk_addr_o >> LO_W) == '0);
  // R5: pop reads at the current pointer
  a_r5_pop_at_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cfg_ext_en_i) |-> stk_addr_o == ptr);
  // R8: low write wins over a step
  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo && (push_i || pop_i)) |=> lo_q == $past(sfr_wdata_i));
  // R10: conflicting or absent strobes hold the pointer
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((push_i == pop_i) && no_wr) |=> $stable(ptr));
endmodule

// File: tb/test_xstack_ptr_unit.sv
module test_xstack_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        we = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        push = 1'b0;
  logic        pop = 1'b0;
  logic [10:0] stk_addr;
  logic        xram;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xstack_ptr_unit i_xstack_ptr_unit (
    .clk_i(clk), .rst_ni(rst_n), .cfg_ext_en_i(ext_en),
    .sfr_addr_i(addr), .sfr_we_i(we), .sfr_wdata_i(wdata), .sfr_rdata_o(rdata),
    .push_i(push), .pop_i(pop), .stk_addr_o(stk_addr), .stk_xram_o(xram)
  );

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  // strobe for one cycle; returns the address shown during it
  task automatic strobe(input logic pu, input logic po, output logic [10:0] a);
    push = pu; pop = po;
    #1 a = stk_addr;
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic chk_ptr(input string req, input logic [7:0] hi, input logic [7:0] lo);
    logic [7:0] d;
    rd(8'h81, d); chk(req, {3'b0, d}, {3'b0, lo});
    rd(8'hB7, d); chk(req, {3'b0, d}, {3'b0, hi});
  endtask

  task automatic t_reset();
    logic [10:0] a;
    chk_ptr("R1 reset", 8'h00, 8'h07);
    strobe(1'b1, 1'b0, a); chk("R4 first push addr", a, 11'h008);
    chk_ptr("R4 after push", 8'h00, 8'h08);
    strobe(1'b0, 1'b1, a); chk("R5 pop addr", a, 11'h008);
    chk_ptr("R5 after pop", 8'h00, 8'h07);
  endtask

  task automatic t_sfr_map();
    logic [7:0] d;
    wr(8'h81, 8'h5A); rd(8'h81, d); chk("R2 low rw", {3'b0, d}, 11'h05A);
    wr(8'hB7, 8'h03); rd(8'hB7, d); chk("R2 high rw", {3'b0, d}, 11'h003);
    rd(8'h80, d); chk("R2 other addr reads 0", {3'b0, d}, 11'h000);
    wr(8'h82, 8'hEE);
    chk_ptr("R2 foreign write ignored", 8'h03, 8'h5A);
  endtask

  task automatic t_hi_mask();
    logic [7:0] d;
    wr(8'hB7, 8'hFD); rd(8'hB7, d); chk("R3 high mask", {3'b0, d}, 11'h005);
  endtask

  task automatic t_wrap8();
    logic [10:0] a;
    ext_en = 1'b0;
    wr(8'hB7, 8'h05); wr(8'h81, 8'hFF);
    strobe(1'b1, 1'b0, a); chk("R6 push wrap addr", a, 11'h000);
    chk_ptr("R6 push wrap ptr", 8'h05, 8'h00);
    strobe(1'b0, 1'b1, a); chk("R6 pop addr", a, 11'h000);
    chk_ptr("R6 pop wrap ptr", 8'h05, 8'hFF);
    #1 chk("R6 idle byte addr", stk_addr, 11'h0FF);
    @(negedge clk);
  endtask

  task automatic t_wrap11();
    logic [10:0] a;
    ext_en = 1'b1;
    wr(8'hB7, 8'h00); wr(8'h81, 8'hFF);
    strobe(1'b1, 1'b0, a); chk("R7 carry addr", a, 11'h100);
    chk_ptr("R7 carry ptr", 8'h01, 8'h00);
    strobe(1'b0, 1'b1, a); chk("R7 borrow addr", a, 11'h100);
    chk_ptr("R7 borrow ptr", 8'h00, 8'hFF);
    wr(8'hB7, 8'h07);
    strobe(1'b1, 1'b0, a); chk("R7 top wrap addr", a, 11'h000);
    chk_ptr("R7 top wrap ptr", 8'h00, 8'h00);
    strobe(1'b0, 1'b1, a); chk("R7 bottom pop addr", a, 11'h000);
    chk_ptr("R7 bottom wrap ptr", 8'h07, 8'hFF);
  endtask

  task automatic t_prio();
    logic [10:0] a;
    ext_en = 1'b1;
    wr(8'hB7, 8'h00); wr(8'h81, 8'h10);
    addr = 8'h81; wdata = 8'h40; we = 1'b1;
    strobe(1'b1, 1'b0, a); we = 1'b0;
    chk_ptr("R8 write beats push", 8'h00, 8'h40);
    addr = 8'hB7; wdata = 8'h02; we = 1'b1;
    strobe(1'b0, 1'b1, a); we = 1'b0;
    chk_ptr("R8 write beats pop", 8'h02, 8'h40);
  endtask

  task automatic t_sel();
    ext_en = 1'b1;
    #1 chk("R9 select xram", {10'b0, xram}, 11'h001);
    chk("R9 ext idle addr", stk_addr, 11'h240);
    ext_en = 1'b0;
    #1 chk("R9 select internal", {10'b0, xram}, 11'h000);
    chk("R6 internal idle addr", stk_addr, 11'h040);
    @(negedge clk);
  endtask

  task automatic t_both();
    logic [10:0] a;
    ext_en = 1'b1;
    strobe(1'b1, 1'b1, a); chk("R10 both addr", a, 11'h240);
    chk_ptr("R10 both hold", 8'h02, 8'h40);
    tick();
    chk_ptr("R10 idle hold", 8'h02, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sfr_map();
    t_hi_mask();
    t_wrap8();
    t_wrap11();
    t_prio();
    t_sel();
    t_both();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule